// File: doc/BRIEF.md
# Shared-Function Parallel Port with Pulldown Control

This block is one parallel I/O port of a small microcontroller. Each pin has three per-bit controls, all reached over a simple CPU register bus: an output latch, a direction bit and a pulldown enable. A read of the data address returns the output latch for pins set as outputs. For pins set as inputs it returns the pin level, taken through a two-flop synchroniser.

One pin, chosen by a parameter, is shared with two other functions. When it is an output, it drives the logical OR of its latch bit, the timer compare level and the output of an analog comparator. When it is an input, it drives nothing, so neither the timer nor the comparator can reach the pad.

A pin's pulldown is enabled only when three conditions hold: the pin is an input, its pulldown bit is set, and the global pulldown-inhibit option is clear. The pulldown register is write-only. Its reset value is a parameter, all ones by default.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset the direction register is all zeros (`pin_oe` = 0x00), the output latch is all zeros, and the pulldown register holds its reset value (0xFF by default). So with the inhibit clear, `pin_pd_en` = 0xFF.
- R2: A write to the data address (0x01) loads the output latch. A read of the data address returns the latch bit for every pin whose direction bit is 1.
- R3: A write to the direction address (0x05) loads the direction register. Reads of that address return it, and `pin_oe` equals it from the next cycle onwards.
- R4: The shared pin (bit 4 by default), when its direction bit is 1, drives the OR of its latch bit, `timer_cmp_lvl` and `cmp_out`.
- R5: Every other output pin drives its latch bit. Every pin whose direction bit is 0 drives 0 on `pin_out`, including the shared pin whatever the timer and comparator levels.
- R6: The pulldown address (0x11) is write-only: a write loads the pulldown register, and a read returns 0x00.
- R7: `pin_pd_en[i]` is 1 exactly when the direction bit is 0, the pulldown bit is 1 and `pd_inhibit` is 0.
- R8: For a pin whose direction bit is 0, a read of the data address returns the value `pin_in` had two clock edges earlier. A value applied before only one edge is not yet visible.
- R9: A write to an unmapped address changes no register, and a read of an unmapped address returns 0x00.
- R10: `bus_rdata` is 0x00 whenever no read is in progress (`bus_sel` low or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| timer_cmp_lvl | input | 1 | Timer output-compare level for the shared pin |
| cmp_out | input | 1 | Analog comparator output for the shared pin |
| pd_inhibit | input | 1 | Global option: forces every pulldown off |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pd_en | output | 8 | Pad pulldown enables |

## Verification
The embedded properties assume that bus strobes, address and write data are stable around each rising edge. They also assume the bus is idle while reset is asserted, so a write is never masked by reset inside a checked window. The bench drives every input only on the falling edge and holds the bus idle during reset. The timer and comparator levels are treated as free inputs and change only between register accesses. Pin inputs change only at falling edges, so the two-edge synchroniser delay can be counted exactly.

// File: rtl/gpio_port_pkg.sv
// Package: shared types for the parallel port.
// Assumes: nothing; pure type definitions.
package gpio_port_pkg;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DATA = 2'd1,
        REG_DIR  = 2'd2,
        REG_PD   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for the pad input levels.
// Assumes: pin_in is asynchronous; the output settles two edges after a change.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two sampling stages with a synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R8: the second stage always takes what the first stage held
    p_stage_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage2_q == $past(stage1_q));

endmodule

// File: rtl/gpio_regs.sv
// Module: address decode and the three per-pin control registers.
// Assumes: single-cycle writes qualified by sel & wr; addresses are parameters.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int           W       = 8,
    parameter int           AW      = 8,
    parameter logic [AW-1:0] A_DATA = 8'h01,
    parameter logic [AW-1:0] A_DIR  = 8'h05,
    parameter logic [AW-1:0] A_PD   = 8'h11,
    parameter logic [W-1:0]  PD_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output reg_sel_e      reg_hit,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  pd_q
);

    logic wr_data;
    logic wr_dir;
    logic wr_pd;

    // Decode the address into a register select
    always_comb begin
        if (addr == A_DATA)      reg_hit = REG_DATA;
        else if (addr == A_DIR)  reg_hit = REG_DIR;
        else if (addr == A_PD)   reg_hit = REG_PD;
        else                     reg_hit = REG_NONE;
    end

    // Qualify per-register write strobes
    always_comb begin
        wr_data = sel && wr && (reg_hit == REG_DATA);
        wr_dir  = sel && wr && (reg_hit == REG_DIR);
        wr_pd   = sel && wr && (reg_hit == REG_PD);
    end

    // Output latch
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= wdata;
    end

    // Direction register: every pin starts as an input
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Write-only pulldown register
    always_ff @(posedge clk) begin
        if (!rst_n)     pd_q <= PD_RST;
        else if (wr_pd) pd_q <= wdata;
    end

    // R2: a data write lands in the latch
    p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == A_DATA) |=> data_q == $past(wdata));

    // R3: direction holds unless written
    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr && addr == A_DIR) |=> $stable(dir_q));

    // R6: a pulldown write lands in the register
    p_pd_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == A_PD) |=> pd_q == $past(wdata));

    // R9: writes to unmapped addresses leave every register unchanged
    p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr != A_DATA && addr != A_DIR && addr != A_PD)
        |=> $stable(data_q) && $stable(dir_q) && $stable(pd_q));

endmodule

// File: rtl/gpio_pin_ctl.sv
// Module: per-pin output value, output enable and pulldown enable.
// Assumes: SHARED_IDX names the one pin that mixes in timer and comparator.
module gpio_pin_ctl #(
    parameter int W          = 8,
    parameter int SHARED_IDX = 4
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pd_q,
    input  logic         timer_lvl,
    input  logic         cmp_lvl,
    input  logic         pd_inhibit,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pd_en
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic drive_val;

        if (i == SHARED_IDX) begin : g_shared
            // Shared pin: latch OR timer level OR comparator
            always_comb drive_val = data_q[i] | timer_lvl | cmp_lvl;
        end else begin : g_plain
            // Plain pin: latch only
            always_comb drive_val = data_q[i];
        end

        // Gate value, enables by direction and pulldown conditions
        always_comb begin
            pin_oe[i]    = dir_q[i];
            pin_out[i]   = dir_q[i] & drive_val;
            pin_pd_en[i] = ~dir_q[i] & pd_q[i] & ~pd_inhibit;
        end
    end

    // R7: a pulldown is never on for a driven pin
    always_comb begin
        p_pd_vs_oe_r7: assert ((pin_pd_en & pin_oe) == '0);
    end

    // R7: inhibit clears every pulldown
    always_comb begin
        p_inhibit_r7: assert (!pd_inhibit || pin_pd_en == '0);
    end

    // R5: an undriven pin never shows a high output value
    always_comb begin
        p_input_quiet_r5: assert ((pin_out & ~pin_oe) == '0);
    end

endmodule

// File: rtl/gpio_readback.sv
// Module: read data selection for the register bus.
// Assumes: reads are combinational and only valid while sel & ~wr.
module gpio_readback
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic         wr,
    input  reg_sel_e     reg_hit,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rdata
);

    logic [W-1:0] mux_val;

    // Pick the source per address; the pulldown address reads as zero
    always_comb begin
        unique case (reg_hit)
            REG_DATA: mux_val = (data_q & dir_q) | (pin_sync & ~dir_q);
            REG_DIR:  mux_val = dir_q;
            default:  mux_val = '0;
        endcase
    end

    // Drive data only during a read
    assign rdata = (sel && !wr) ? mux_val : '0;

    // R6: the write-only address reads zero
    always_comb begin
        p_pd_reads_zero_r6: assert (reg_hit != REG_PD || rdata == '0);
    end

    // R10: idle bus returns zero
    always_comb begin
        p_idle_zero_r10: assert ((sel && !wr) || rdata == '0);
    end

endmodule

// File: rtl/gpio_shared_port.sv
// Module: top of the parallel port with one shared-function pin.
// Assumes: synchronous active-low reset; bus idle while reset is low.
module gpio_shared_port
    import gpio_port_pkg::*;
#(
    parameter int            W          = 8,
    parameter int            AW         = 8,
    parameter int            SHARED_IDX = 4,
    parameter logic [AW-1:0] A_DATA     = 8'h01,
    parameter logic [AW-1:0] A_DIR      = 8'h05,
    parameter logic [AW-1:0] A_PD       = 8'h11,
    parameter logic [W-1:0]  PD_RST     = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    input  logic          timer_cmp_lvl,
    input  logic          cmp_out,
    input  logic          pd_inhibit,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_pd_en
);

    reg_sel_e     reg_hit;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pd_q;
    logic [W-1:0] pin_sync;

    gpio_regs #(
        .W(W), .AW(AW), .A_DATA(A_DATA), .A_DIR(A_DIR), .A_PD(A_PD), .PD_RST(PD_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .reg_hit(reg_hit),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pd_q   (pd_q)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pin_in),
        .sync_out(pin_sync)
    );

    gpio_pin_ctl #(.W(W), .SHARED_IDX(SHARED_IDX)) u_pins (
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pd_q      (pd_q),
        .timer_lvl (timer_cmp_lvl),
        .cmp_lvl   (cmp_out),
        .pd_inhibit(pd_inhibit),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pd_en (pin_pd_en)
    );

    gpio_readback #(.W(W)) u_rd (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .reg_hit (reg_hit),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pin_sync(pin_sync),
        .rdata   (bus_rdata)
    );

    // R3: output enables follow a direction write on the next cycle
    p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata));

    // R1: the first cycle out of reset shows no output enable
    p_reset_oe_r1: assert property (@(posedge clk)
        !rst_n |=> pin_oe == '0);

    // R4: a driven shared pin is high whenever timer or comparator is high
    p_shared_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[SHARED_IDX] && (timer_cmp_lvl || cmp_out)) |-> pin_out[SHARED_IDX]);

endmodule

// File: tb/gpio_shared_port_tb.sv
module gpio_shared_port_tb;

    localparam logic [7:0] A_DATA = 8'h01;
    localparam logic [7:0] A_DIR  = 8'h05;
    localparam logic [7:0] A_PD   = 8'h11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic       timer_cmp_lvl = 1'b0;
    logic       cmp_out = 1'b0;
    logic       pd_inhibit = 1'b0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pin_pd_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_shared_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .timer_cmp_lvl(timer_cmp_lvl), .cmp_out(cmp_out),
        .pd_inhibit(pd_inhibit), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pd_en(pin_pd_en)
    );

    // Vector: {dir, data, timer, cmp, expected pin_out}
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {8'hFF, 8'h00, 1'b0, 1'b0, 8'h00},
        {8'hFF, 8'h00, 1'b1, 1'b0, 8'h10},
        {8'hFF, 8'h00, 1'b0, 1'b1, 8'h10},
        {8'hFF, 8'hA5, 1'b0, 1'b0, 8'hA5},
        {8'h0F, 8'hFF, 1'b1, 1'b1, 8'h0F},
        {8'hF0, 8'h0F, 1'b1, 1'b0, 8'h10},
        {8'h10, 8'h10, 1'b0, 1'b0, 8'h10},
        {8'hEF, 8'h00, 1'b1, 1'b1, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R1 pd_en", pin_pd_en, 8'hFF);
        bus_read(A_DIR, rd);  check("R1 dir read", rd, 8'h00);

        // R10: idle bus reads zero
        @(negedge clk); bus_addr = A_DIR;
        #1 check("R10 idle", bus_rdata, 8'h00);

        // Vector walk: R3, R4, R5
        for (int k = 0; k < NV; k++) begin
            bus_write(A_DIR, VEC[k][25:18]);
            bus_write(A_DATA, VEC[k][17:10]);
            timer_cmp_lvl = VEC[k][9];
            cmp_out = VEC[k][8];
            #1;
            check("R3 oe", pin_oe, VEC[k][25:18]);
            check("R4/R5 out", pin_out, VEC[k][7:0]);
        end
        timer_cmp_lvl = 1'b0; cmp_out = 1'b0;

        // R2: data read-back on output pins
        bus_write(A_DIR, 8'hFF);
        bus_write(A_DATA, 8'h3C);
        bus_read(A_DATA, rd); check("R2 data read", rd, 8'h3C);
        bus_read(A_DIR, rd);  check("R3 dir read", rd, 8'hFF);

        // R8: synchroniser delay on input pins
        bus_write(A_DIR, 8'h00);
        @(negedge clk); pin_in = 8'h5A;
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_DATA;
        #1 check("R8 one edge", bus_rdata, 8'h00);
        @(negedge clk);
        #1 check("R8 two edges", bus_rdata, 8'h5A);
        bus_sel = 1'b0;

        // R2/R8: mixed directions
        bus_write(A_DIR, 8'hF0);
        bus_write(A_DATA, 8'hC3);
        bus_read(A_DATA, rd); check("R2/R8 mixed", rd, 8'hCA);

        // R6 and R7: pulldowns
        bus_write(A_DIR, 8'h00);
        bus_write(A_PD, 8'h33);
        check("R6 pd write", pin_pd_en, 8'h33);
        bus_read(A_PD, rd); check("R6 pd read zero", rd, 8'h00);
        bus_write(A_DIR, 8'h03);
        check("R7 dir masks pd", pin_pd_en, 8'h30);
        pd_inhibit = 1'b1; #1;
        check("R7 inhibit", pin_pd_en, 8'h00);
        pd_inhibit = 1'b0; #1;
        check("R7 inhibit release", pin_pd_en, 8'h30);

        // R9: unmapped write and read
        bus_write(8'h02, 8'hFF);
        bus_read(A_DIR, rd);  check("R9 dir unchanged", rd, 8'h03);
        bus_read(A_DATA, rd); check("R9 data unchanged", rd, 8'h5B);
        check("R9 pd unchanged", pin_pd_en, 8'h30);
        bus_read(8'h02, rd);  check("R9 unmapped read", rd, 8'h00);

        // R1: reset again restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 re-reset oe", pin_oe, 8'h00);
        check("R1 re-reset pd", pin_pd_en, 8'hFF);

        finish_run();
    end

endmodule